// File: doc/BRIEF.md
# Prioritized Power-State Trigger Controller

This block decides the next power state of a system power manager. On every cycle in which no power sequence is running, it looks at a set of trigger inputs. These are shutdown and error requests, watchdog and error-signalling faults, on and MCU-on requests, two wake pins, two sleep lines with register overrides, and four self-clearing command bits. From the triggers that are allowed in the current state, it picks the one with the highest rank. It then issues a one-cycle `go_o` pulse together with a sequence code and a target state.

Rail sequencing lies outside the block. An external sequencer runs the sequence and answers with `seq_done_i`, and only then does the block commit the target as its current state. While a sequence is running, only the three immediate shutdown triggers can take over.

A recovery counter counts each entry into SAFE. Below the programmed threshold, SAFE returns to STANDBY on its own. When the count reaches the threshold, the block halts until reset. A CRC-enable command also raises a flag that takes the second host interface offline for 2 ms.

Top module: `pst_ctrl`

## Requirements
- R1: While `rst_ni` is low, every output is zero. This means `state_o` is STANDBY (0), `busy_o`, `go_o`, `halt_o` and `if2_dis_o` are 0, and `seq_o`, `tgt_o` and `recov_cnt_o` are 0.
- R2: Trigger rank runs from ID 0 (highest) to ID 22 (lowest). A trigger is active when its condition holds and the current state is in its allowed set. Only the highest-ranked active trigger is acted on. If that trigger is not re-entrant and its target equals the current state, no sequence starts, and every lower trigger stays blocked.
- R3: If a trigger is present while the block is idle, `go_o` is high for exactly one cycle in the next cycle. In that same cycle `busy_o` rises, and `seq_o` and `tgt_o` are loaded and then held. `state_o` takes the value of `tgt_o` in the cycle after `seq_done_i` is seen high while busy, and it changes at no other time.
- R4: Immediate shutdown (ID 0), MCU power error (ID 1) and orderly shutdown (ID 2) each target SAFE (`tgt_o`=4) from STANDBY, ACTIVE, MCU_ONLY or SUSPEND. Their sequence codes are 1, 2 and 3.
- R5: While busy, a new `go_o` can only come from an immediate trigger (ID 0..2) whose rank is higher than that of the running sequence. All other triggers wait for the block to become idle.
- R6: The following triggers each map to a fixed target and code:
  - OFF request (ID 4) goes to STANDBY (0) with code 4 from any of the four operating states.
  - Watchdog error in ACTIVE (ID 5) re-enters ACTIVE (1) with code 5.
  - Watchdog error in MCU_ONLY (ID 8) re-enters MCU_ONLY (2) with code 7.
  - SoC error-signal fault in ACTIVE (ID 7) goes to MCU_ONLY with code 6.
  - SoC power error in ACTIVE (ID 10) goes to MCU_ONLY with code 8.
- R7: The following triggers select the target state:
  - ON request (ID 13), WKUP1 (ID 14), or both sleep lines high (ID 15) target ACTIVE with code 11.
  - MCU-on request (ID 16), WKUP2 (ID 17), or sleep1 low with sleep2 high (ID 18) target MCU_ONLY with code 12.
  - Both sleep lines low (ID 19), or sleep1 high with sleep2 low (ID 20), target SUSPEND (3) with code 13, allowed only from ACTIVE or MCU_ONLY.
- R8: Each effective sleep level is the OR of its pin and its register bit. The sleep triggers (IDs 15, 18, 19, 20) are considered only when `sleep_mask_i` is 2'b00.
- R9: A pulse on a bit of `cmd_set_i` sets a pending command, which clears itself when its sequence starts. The bits behave as follows:
  - Bit 1 (ID 11) starts code 9.
  - Bit 2 (ID 12) starts code 10.
  - Bit 0 (ID 21) targets STANDBY, or LP_STANDBY (5) when `lp_sel_i` is 1, with code 4. It is only considered when `sleep_mask_i` is 2'b11.
  - Bit 3 (ID 22) starts code 14. It is only considered when `sleep_mask_i` is 2'b11.
  - Bits 1, 2 and 3 keep the current state as target.
- R10: `if2_dis_o` goes high in the cycle of the code-10 `go_o` and stays high for exactly 2*`CLK_KHZ` cycles.
- R11: `recov_cnt_o` increments by one, saturating, when a sequence with target SAFE completes. In SAFE and not halted, the block then starts code 15 with target STANDBY by itself.
- R12: When the incremented count is greater than or equal to `recov_thr_i`, `halt_o` rises with the SAFE entry. From then until reset, no `go_o` is issued.
- R13: LP_STANDBY is left only by the ON request or WKUP1, both of which go to ACTIVE. Other triggers have no effect there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imm_shdn_i | input | 1 | Immediate shutdown request (ID 0) |
| mcu_pwr_err_i | input | 1 | MCU rail power error (ID 1) |
| ord_shdn_i | input | 1 | Orderly shutdown request (ID 2) |
| off_req_i | input | 1 | OFF request (ID 4) |
| wdog_err_i | input | 1 | Watchdog error (ID 5 / ID 8) |
| esm_soc_err_i | input | 1 | SoC error-signal fault (ID 7) |
| soc_pwr_err_i | input | 1 | SoC power error (ID 10) |
| on_req_i | input | 1 | ON request (ID 13) |
| wkup1_i | input | 1 | Wake pin 1 high (ID 14) |
| mcu_on_req_i | input | 1 | MCU-on request (ID 16) |
| wkup2_i | input | 1 | Wake pin 2 high (ID 17) |
| nsleep1_pin_i | input | 1 | Sleep line 1 pin level |
| nsleep2_pin_i | input | 1 | Sleep line 2 pin level |
| nsleep1_reg_i | input | 1 | Sleep line 1 register override |
| nsleep2_reg_i | input | 1 | Sleep line 2 register override |
| sleep_mask_i | input | 2 | Sleep mask bits |
| cmd_set_i | input | 4 | Set pulses for the four command bits |
| lp_sel_i | input | 1 | Command bit 0 goes to LP_STANDBY when 1 |
| recov_thr_i | input | CNT_W | Recovery count threshold |
| seq_done_i | input | 1 | Running sequence has finished |
| state_o | output | 3 | Current state |
| busy_o | output | 1 | Sequence running |
| go_o | output | 1 | One-cycle start of a sequence |
| seq_o | output | 4 | Sequence code |
| tgt_o | output | 3 | Target state of the sequence |
| if2_dis_o | output | 1 | Second interface disabled after CRC enable |
| recov_cnt_o | output | CNT_W | SAFE recovery count |
| halt_o | output | 1 | Recovery halted |

## Verification
`go_o`, `seq_o`, `tgt_o` and `busy_o` are due one clock after a trigger input is applied. The exception is a command bit, which is registered as pending first and so is due two clocks after its set pulse. `state_o`, `recov_cnt_o` and `halt_o` change one clock after `seq_done_i` is sampled. The automatic recovery pulse follows one clock later. `if2_dis_o` rises together with the code-10 pulse and is measured over its whole window. The bench drives inputs and samples outputs on the falling edge, so every directed check and every per-cycle comparison with the reference model falls on the exact cycle these latencies give.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int NUM_TRIG = 23;
  localparam int ID_W     = $clog2(NUM_TRIG + 1);
  localparam int NUM_CMD  = 4;

  // trigger ids of the command bits, index = command bit
  localparam int ID_CMD0 = 21;
  localparam int ID_CMD1 = 11;
  localparam int ID_CMD2 = 12;
  localparam int ID_CMD3 = 22;

  typedef enum logic [2:0] {
    ST_STBY   = 3'd0,
    ST_ACT    = 3'd1,
    ST_MCU    = 3'd2,
    ST_SUSP   = 3'd3,
    ST_SAFE   = 3'd4,
    ST_LPSTBY = 3'd5
  } pstate_e;

  typedef enum logic [3:0] {
    SQ_NONE     = 4'd0,
    SQ_SEVERE   = 4'd1,
    SQ_SAFE     = 4'd2,
    SQ_ORDERLY  = 4'd3,
    SQ_STBY     = 4'd4,
    SQ_ACT_WARM = 4'd5,
    SQ_SOC_ESM  = 4'd6,
    SQ_MCU_WARM = 4'd7,
    SQ_SOC_PWR  = 4'd8,
    SQ_BIST     = 4'd9,
    SQ_CRC      = 4'd10,
    SQ_ACT      = 4'd11,
    SQ_MCU      = 4'd12,
    SQ_RET      = 4'd13,
    SQ_OTA      = 4'd14,
    SQ_RECOV    = 4'd15
  } pseq_e;

  typedef struct packed {
    logic    act;
    pstate_e tgt;
    pseq_e   seq;
    logic    reent;
    logic    imm;
  } trig_t;
endpackage

// File: rtl/pst_trig_map.sv
module pst_trig_map
  import pst_pkg::*;
(
  input  pstate_e               state_i,
  input  logic                  imm_shdn_i,
  input  logic                  mcu_pwr_err_i,
  input  logic                  ord_shdn_i,
  input  logic                  off_req_i,
  input  logic                  wdog_err_i,
  input  logic                  esm_soc_err_i,
  input  logic                  soc_pwr_err_i,
  input  logic                  on_req_i,
  input  logic                  wkup1_i,
  input  logic                  mcu_on_req_i,
  input  logic                  wkup2_i,
  input  logic                  sl1_i,
  input  logic                  sl2_i,
  input  logic [1:0]            sleep_mask_i,
  input  logic [NUM_CMD-1:0]    cmd_pend_i,
  input  logic                  lp_sel_i,
  output trig_t [NUM_TRIG-1:0]  tbl_o
);
  logic in_act, in_mcu, in_oper, in_am, in_lp, sl_en, cm_en;

  assign in_act  = (state_i == ST_ACT);
  assign in_mcu  = (state_i == ST_MCU);
  assign in_am   = in_act | in_mcu;
  assign in_oper = in_am | (state_i == ST_STBY) | (state_i == ST_SUSP);
  assign in_lp   = (state_i == ST_LPSTBY);
  assign sl_en   = (sleep_mask_i == 2'b00);
  assign cm_en   = (sleep_mask_i == 2'b11);

  function automatic trig_t mk(logic a, pstate_e t, pseq_e s, logic r, logic i);
    trig_t v;
    v.act   = a;
    v.tgt   = t;
    v.seq   = s;
    v.reent = r;
    v.imm   = i;
    return v;
  endfunction

  always_comb begin
    for (int k = 0; k < NUM_TRIG; k++) tbl_o[k] = mk(1'b0, ST_STBY, SQ_NONE, 1'b0, 1'b0);
    // immediate shutdowns
    tbl_o[0]  = mk(imm_shdn_i    & in_oper, ST_SAFE, SQ_SEVERE,  1'b0, 1'b1);
    tbl_o[1]  = mk(mcu_pwr_err_i & in_oper, ST_SAFE, SQ_SAFE,    1'b0, 1'b1);
    tbl_o[2]  = mk(ord_shdn_i    & in_oper, ST_SAFE, SQ_ORDERLY, 1'b0, 1'b1);
    tbl_o[4]  = mk(off_req_i     & in_oper, ST_STBY, SQ_STBY,    1'b0, 1'b0);
    // faults
    tbl_o[5]  = mk(wdog_err_i    & in_act,  ST_ACT,  SQ_ACT_WARM, 1'b1, 1'b0);
    tbl_o[7]  = mk(esm_soc_err_i & in_act,  ST_MCU,  SQ_SOC_ESM,  1'b1, 1'b0);
    tbl_o[8]  = mk(wdog_err_i    & in_mcu,  ST_MCU,  SQ_MCU_WARM, 1'b1, 1'b0);
    tbl_o[10] = mk(soc_pwr_err_i & in_act,  ST_MCU,  SQ_SOC_PWR,  1'b0, 1'b0);
    // in-place commands
    tbl_o[ID_CMD1] = mk(cmd_pend_i[1] & in_am, state_i, SQ_BIST, 1'b1, 1'b0);
    tbl_o[ID_CMD2] = mk(cmd_pend_i[2] & in_am, state_i, SQ_CRC,  1'b1, 1'b0);
    // wake to ACTIVE
    tbl_o[13] = mk(on_req_i & (in_oper | in_lp),           ST_ACT, SQ_ACT, 1'b0, 1'b0);
    tbl_o[14] = mk(wkup1_i  & (in_oper | in_lp),           ST_ACT, SQ_ACT, 1'b0, 1'b0);
    tbl_o[15] = mk(sl_en & sl1_i & sl2_i & in_oper,        ST_ACT, SQ_ACT, 1'b0, 1'b0);
    // to MCU_ONLY
    tbl_o[16] = mk(mcu_on_req_i & in_oper,                 ST_MCU, SQ_MCU, 1'b0, 1'b0);
    tbl_o[17] = mk(wkup2_i      & in_oper,                 ST_MCU, SQ_MCU, 1'b0, 1'b0);
    tbl_o[18] = mk(sl_en & ~sl1_i & sl2_i & (in_am | (state_i == ST_SUSP)),
                   ST_MCU, SQ_MCU, 1'b0, 1'b0);
    // to SUSPEND
    tbl_o[19] = mk(sl_en & ~sl1_i & ~sl2_i & in_am,        ST_SUSP, SQ_RET, 1'b0, 1'b0);
    tbl_o[20] = mk(sl_en &  sl1_i & ~sl2_i & in_am,        ST_SUSP, SQ_RET, 1'b0, 1'b0);
    // masked-sleep commands
    tbl_o[ID_CMD0] = mk(cm_en & cmd_pend_i[0] & (in_am | (state_i == ST_STBY)),
                        lp_sel_i ? ST_LPSTBY : ST_STBY, SQ_STBY, 1'b1, 1'b0);
    tbl_o[ID_CMD3] = mk(cm_en & cmd_pend_i[3] & in_am, state_i, SQ_OTA, 1'b1, 1'b0);
  end
endmodule

// File: rtl/pst_pick.sv
module pst_pick #(
  parameter int N    = 23,
  parameter int ID_W = 5
) (
  input  logic [N-1:0]    act_i,
  output logic            vld_o,
  output logic [ID_W-1:0] id_o
);
  logic [N:0]   above;
  logic [N-1:0] first;

  assign above[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_rank
    assign first[g]   = act_i[g] & ~above[g];
    assign above[g+1] = above[g] | act_i[g];
  end

  assign vld_o = above[N];

  always_comb begin
    id_o = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) id_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/pst_hold.sv
module pst_hold #(
  parameter int CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic flag_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign flag_o = (cnt_q != '0);
endmodule

// File: rtl/pst_recov.sv
module pst_recov #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             halt_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             halt_q;

  assign cnt_nx = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (inc_i) begin
      cnt_q  <= cnt_nx;
      halt_q <= halt_q | (cnt_nx >= thr_i);
    end
  end

  assign cnt_o  = cnt_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/pst_ctrl.sv
module pst_ctrl
  import pst_pkg::*;
#(
  parameter int CLK_KHZ = 32,
  parameter int CNT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             imm_shdn_i,
  input  logic             mcu_pwr_err_i,
  input  logic             ord_shdn_i,
  input  logic             off_req_i,
  input  logic             wdog_err_i,
  input  logic             esm_soc_err_i,
  input  logic             soc_pwr_err_i,
  input  logic             on_req_i,
  input  logic             wkup1_i,
  input  logic             mcu_on_req_i,
  input  logic             wkup2_i,
  input  logic             nsleep1_pin_i,
  input  logic             nsleep2_pin_i,
  input  logic             nsleep1_reg_i,
  input  logic             nsleep2_reg_i,
  input  logic [1:0]       sleep_mask_i,
  input  logic [3:0]       cmd_set_i,
  input  logic             lp_sel_i,
  input  logic [CNT_W-1:0] recov_thr_i,
  input  logic             seq_done_i,
  output logic [2:0]       state_o,
  output logic             busy_o,
  output logic             go_o,
  output logic [3:0]       seq_o,
  output logic [2:0]       tgt_o,
  output logic             if2_dis_o,
  output logic [CNT_W-1:0] recov_cnt_o,
  output logic             halt_o
);
  localparam int HOLD_CYC = 2 * CLK_KHZ;  // 2 ms
  localparam logic [ID_W-1:0] RUN_NONE = ID_W'(NUM_TRIG);

  pstate_e                state_q, tgt_q;
  pseq_e                  seq_q;
  logic                   busy_q, go_q;
  logic [ID_W-1:0]        run_q;
  logic [NUM_CMD-1:0]     pend_q, take;
  trig_t [NUM_TRIG-1:0]   tbl;
  logic [NUM_TRIG-1:0]    act_vec;
  logic                   win_vld;
  logic [ID_W-1:0]        win_id;
  trig_t                  win;
  logic                   halted, auto_rec, fire, start, preempt, safe_in, crc_go;
  pstate_e                nx_tgt;
  pseq_e                  nx_seq;
  logic [ID_W-1:0]        nx_id;

  pst_trig_map i_map (
    .state_i       (state_q),
    .imm_shdn_i    (imm_shdn_i),
    .mcu_pwr_err_i (mcu_pwr_err_i),
    .ord_shdn_i    (ord_shdn_i),
    .off_req_i     (off_req_i),
    .wdog_err_i    (wdog_err_i),
    .esm_soc_err_i (esm_soc_err_i),
    .soc_pwr_err_i (soc_pwr_err_i),
    .on_req_i      (on_req_i),
    .wkup1_i       (wkup1_i),
    .mcu_on_req_i  (mcu_on_req_i),
    .wkup2_i       (wkup2_i),
    .sl1_i         (nsleep1_pin_i | nsleep1_reg_i),
    .sl2_i         (nsleep2_pin_i | nsleep2_reg_i),
    .sleep_mask_i  (sleep_mask_i),
    .cmd_pend_i    (pend_q),
    .lp_sel_i      (lp_sel_i),
    .tbl_o         (tbl)
  );

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_act
    assign act_vec[g] = tbl[g].act;
  end

  pst_pick #(.N(NUM_TRIG), .ID_W(ID_W)) i_pick (
    .act_i (act_vec),
    .vld_o (win_vld),
    .id_o  (win_id)
  );

  assign win = tbl[win_id];

  // winner blocks lower triggers even when it does not fire
  assign fire     = win_vld & win.act & (win.reent | (win.tgt != state_q));
  assign auto_rec = (state_q == ST_SAFE) & ~halted & ~busy_q;
  assign start    = ~busy_q & ~halted & (auto_rec | fire);
  assign preempt  = busy_q & ~halted & win_vld & win.imm & (win_id < run_q);
  assign safe_in  = busy_q & seq_done_i & ~preempt & (tgt_q == ST_SAFE);
  assign crc_go   = start & ~auto_rec & (win_id == ID_W'(ID_CMD2));

  assign nx_tgt = auto_rec ? ST_STBY  : win.tgt;
  assign nx_seq = auto_rec ? SQ_RECOV : win.seq;
  assign nx_id  = auto_rec ? RUN_NONE : win_id;

  always_comb begin
    take = '0;
    if (start & ~auto_rec) begin
      take[0] = (win_id == ID_W'(ID_CMD0));
      take[1] = (win_id == ID_W'(ID_CMD1));
      take[2] = (win_id == ID_W'(ID_CMD2));
      take[3] = (win_id == ID_W'(ID_CMD3));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~take) | cmd_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STBY;
      tgt_q   <= ST_STBY;
      seq_q   <= SQ_NONE;
      busy_q  <= 1'b0;
      go_q    <= 1'b0;
      run_q   <= RUN_NONE;
    end else begin
      go_q <= 1'b0;
      if (start | preempt) begin
        go_q   <= 1'b1;
        busy_q <= 1'b1;
        tgt_q  <= nx_tgt;
        seq_q  <= nx_seq;
        run_q  <= nx_id;
      end else if (busy_q & seq_done_i) begin
        busy_q  <= 1'b0;
        state_q <= tgt_q;
      end
    end
  end

  pst_recov #(.CNT_W(CNT_W)) i_recov (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (safe_in),
    .thr_i  (recov_thr_i),
    .cnt_o  (recov_cnt_o),
    .halt_o (halted)
  );

  pst_hold #(.CYC(HOLD_CYC)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (crc_go),
    .flag_o  (if2_dis_o)
  );

  assign state_o = state_q;
  assign busy_o  = busy_q;
  assign go_o    = go_q;
  assign seq_o   = seq_q;
  assign tgt_o   = tgt_q;
  assign halt_o  = halted;
endmodule

// File: rtl/pst_ctrl_chk.sv
module pst_ctrl_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       state_o,
  input logic             busy_o,
  input logic             go_o,
  input logic [3:0]       seq_o,
  input logic [2:0]       tgt_o,
  input logic             seq_done_i,
  input logic [CNT_W-1:0] recov_cnt_o,
  input logic             halt_o
);
  AST_GO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> busy_o);  // R3
  AST_STATE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_o) |-> $past(busy_o && seq_done_i));  // R3
  AST_SAFE_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && tgt_o == 3'd4) |-> (seq_o == 4'd1 || seq_o == 4'd2 || seq_o == 4'd3));  // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(recov_cnt_o) |-> (recov_cnt_o == $past(recov_cnt_o) + 1'b1));  // R11
  AST_RECOV_FROM_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && seq_o == 4'd15) |-> (state_o == 3'd4 && tgt_o == 3'd0));  // R11
  AST_HALT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);  // R12
  AST_HALT_NO_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !go_o);  // R12
endmodule

bind pst_ctrl pst_ctrl_chk #(.CNT_W(CNT_W)) i_pst_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_o     (state_o),
  .busy_o      (busy_o),
  .go_o        (go_o),
  .seq_o       (seq_o),
  .tgt_o       (tgt_o),
  .seq_done_i  (seq_done_i),
  .recov_cnt_o (recov_cnt_o),
  .halt_o      (halt_o)
);

// File: tb/test_pst_ctrl.sv
`timescale 1ns/1ps
module test_pst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ        = 32;
  localparam int HOLD       = 2 * KHZ;
  localparam int CW         = 3;
  localparam int WD_LIMIT   = 20000;

  logic clk = 0, rst_n = 0;
  logic imm = 0, mpe = 0, ord = 0, off = 0, wdog = 0, esm = 0, spe = 0;
  logic on = 0, wk1 = 0, mon = 0, wk2 = 0;
  logic p1 = 0, p2 = 0, r1 = 0, r2 = 0;
  logic [1:0] mask = 0;
  logic [3:0] cset = 0;
  logic lp = 0;
  logic [CW-1:0] thr = 3'd2;
  logic done = 0;
  logic [2:0] state, tgt;
  logic busy, go, if2, halt;
  logic [3:0] seq;
  logic [CW-1:0] rcnt;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pst_ctrl #(.CLK_KHZ(KHZ), .CNT_W(CW)) i_pst_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .imm_shdn_i(imm), .mcu_pwr_err_i(mpe), .ord_shdn_i(ord), .off_req_i(off),
    .wdog_err_i(wdog), .esm_soc_err_i(esm), .soc_pwr_err_i(spe),
    .on_req_i(on), .wkup1_i(wk1), .mcu_on_req_i(mon), .wkup2_i(wk2),
    .nsleep1_pin_i(p1), .nsleep2_pin_i(p2), .nsleep1_reg_i(r1), .nsleep2_reg_i(r2),
    .sleep_mask_i(mask), .cmd_set_i(cset), .lp_sel_i(lp), .recov_thr_i(thr),
    .seq_done_i(done),
    .state_o(state), .busy_o(busy), .go_o(go), .seq_o(seq), .tgt_o(tgt),
    .if2_dis_o(if2), .recov_cnt_o(rcnt), .halt_o(halt)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  int m_state = 0, m_tgt = 0, m_seq = 0, m_run = 23, m_cnt = 0, m_hold = 0;
  bit m_busy = 0, m_go = 0, m_halt = 0;
  bit [3:0] m_pend = 0;

  function automatic void ref_pick(output int wid, output int wt, output int ws,
                                   output bit wr, output bit wi);
    bit s1, s2, sen, cen, op, ac, mc, am;
    s1  = p1 | r1;
    s2  = p2 | r2;
    sen = (mask == 2'b00);
    cen = (mask == 2'b11);
    ac  = (m_state == 1);
    mc  = (m_state == 2);
    am  = ac | mc;
    op  = (m_state <= 3);
    wid = -1; wt = 0; ws = 0; wr = 0; wi = 0;
    for (int i = 0; i < 23; i++) begin
      bit c, r;
      int t, s;
      c = 0; r = 0; t = 0; s = 0;
      case (i)
        0:  begin c = imm && op; t = 4; s = 1; end
        1:  begin c = mpe && op; t = 4; s = 2; end
        2:  begin c = ord && op; t = 4; s = 3; end
        4:  begin c = off && op; t = 0; s = 4; end
        5:  begin c = wdog && ac; t = 1; s = 5; r = 1; end
        7:  begin c = esm && ac;  t = 2; s = 6; r = 1; end
        8:  begin c = wdog && mc; t = 2; s = 7; r = 1; end
        10: begin c = spe && ac;  t = 2; s = 8; end
        11: begin c = m_pend[1] && am; t = m_state; s = 9;  r = 1; end
        12: begin c = m_pend[2] && am; t = m_state; s = 10; r = 1; end
        13: begin c = on  && (op || m_state == 5); t = 1; s = 11; end
        14: begin c = wk1 && (op || m_state == 5); t = 1; s = 11; end
        15: begin c = sen && s1 && s2 && op; t = 1; s = 11; end
        16: begin c = mon && op; t = 2; s = 12; end
        17: begin c = wk2 && op; t = 2; s = 12; end
        18: begin c = sen && !s1 && s2 && (am || m_state == 3); t = 2; s = 12; end
        19: begin c = sen && !s1 && !s2 && am; t = 3; s = 13; end
        20: begin c = sen && s1 && !s2 && am;  t = 3; s = 13; end
        21: begin c = cen && m_pend[0] && (am || m_state == 0); t = lp ? 5 : 0; s = 4; r = 1; end
        22: begin c = cen && m_pend[3] && am; t = m_state; s = 14; r = 1; end
        default: c = 0;
      endcase
      if (c && wid < 0) begin
        wid = i; wt = t; ws = s; wr = r; wi = (i <= 2);
      end
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_state = 0; m_tgt = 0; m_seq = 0; m_run = 23; m_cnt = 0; m_hold = 0;
      m_busy = 0; m_go = 0; m_halt = 0; m_pend = 0;
    end else begin
      int wid, wt, ws;
      bit wr, wi, aut, st, pre, inc, crc;
      bit [3:0] np;
      ref_pick(wid, wt, ws, wr, wi);
      aut = (m_state == 4) && !m_halt && !m_busy;
      st  = !m_busy && !m_halt && (aut || (wid >= 0 && (wr || wt != m_state)));
      pre = m_busy && !m_halt && wid >= 0 && wi && wid < m_run;
      inc = m_busy && done && !pre && m_tgt == 4;
      crc = st && !aut && wid == 12;
      np = m_pend;
      if (st && !aut) begin
        if (wid == 21) np[0] = 0;
        if (wid == 11) np[1] = 0;
        if (wid == 12) np[2] = 0;
        if (wid == 22) np[3] = 0;
      end
      np = np | cset;
      m_go = 0;
      if (st || pre) begin
        m_go = 1; m_busy = 1;
        if (aut) begin m_tgt = 0; m_seq = 15; m_run = 23; end
        else begin m_tgt = wt; m_seq = ws; m_run = wid; end
      end else if (m_busy && done) begin
        m_busy = 0; m_state = m_tgt;
      end
      if (inc) begin
        if (m_cnt < 7) m_cnt++;
        if (m_cnt >= thr) m_halt = 1;
      end
      if (crc) m_hold = HOLD;
      else if (m_hold > 0) m_hold--;
      m_pend = np;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 state", state, m_state);
      chk("R3 go",    go,    m_go);
      chk("R5 busy",  busy,  m_busy);
      chk("R2 seq",   seq,   m_seq);
      chk("R2 tgt",   tgt,   m_tgt);
      chk("R10 if2",  if2,   m_hold > 0);
      chk("R11 cnt",  rcnt,  m_cnt);
      chk("R12 halt", halt,  m_halt);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_go(int sq, int tg, string tag);
    chk({tag, " go"},  go,  1);
    chk({tag, " seq"}, seq, sq);
    chk({tag, " tgt"}, tgt, tg);
  endtask

  task automatic finish_seq(int tg, string tag);
    done = 1;
    tick();
    done = 0;
    chk({tag, " state"}, state, tg);
    chk({tag, " idle"},  busy,  0);
  endtask

  initial begin
    tick(2);
    // R1: reset values
    chk("R1 state", state, 0); chk("R1 busy", busy, 0); chk("R1 go", go, 0);
    chk("R1 halt", halt, 0); chk("R1 cnt", rcnt, 0); chk("R1 if2", if2, 0);
    chk("R1 seq", seq, 0); chk("R1 tgt", tgt, 0);
    rst_n = 1;
    tick(2);
    chk("R7 no suspend from standby", go, 0);

    // R8: both sleep lines high -> ACTIVE
    p1 = 1; p2 = 1;
    tick(); expect_go(11, 1, "R8");
    tick(); chk("R3 go single", go, 0);
    finish_seq(1, "R3");

    // R2: MCU-on blocked by higher sleep trigger in ACTIVE
    mon = 1;
    tick(3); chk("R2 blocked", busy, 0);
    p1 = 0; r1 = 1;
    tick(2); chk("R8 reg override", busy, 0);
    r1 = 0;
    tick(); expect_go(12, 2, "R7");
    mon = 0;
    finish_seq(2, "R7");

    // R6: watchdog in MCU_ONLY is re-entrant
    wdog = 1;
    tick(); expect_go(7, 2, "R6");
    wdog = 0;
    finish_seq(2, "R6");

    p1 = 1;
    tick(); expect_go(11, 1, "R7");
    finish_seq(1, "R7");
    spe = 1;
    tick(); expect_go(8, 2, "R6");
    spe = 0;
    finish_seq(2, "R6");
    tick(); expect_go(11, 1, "R7");
    finish_seq(1, "R7");
    esm = 1;
    tick(); expect_go(6, 2, "R6");
    esm = 0;
    finish_seq(2, "R6");
    tick(); expect_go(11, 1, "R7");
    finish_seq(1, "R7");
    wdog = 1;
    tick(); expect_go(5, 1, "R6");
    wdog = 0;
    finish_seq(1, "R6");

    // R5: suspend, non-immediate waits, immediate preempts
    p1 = 0; p2 = 0;
    tick(); expect_go(13, 3, "R7");
    off = 1;
    tick(2); chk("R5 no preempt", go, 0);
    off = 0; imm = 1;
    tick(); expect_go(1, 4, "R5");
    imm = 0;
    finish_seq(4, "R4");
    chk("R11 count", rcnt, 1);
    tick(); expect_go(15, 0, "R11");
    finish_seq(0, "R11");
    tick(2); chk("R7 standby ignores sleep low", go, 0);

    // R9/R10: commands with masked sleep
    mask = 2'b11; on = 1;
    tick(); expect_go(11, 1, "R7");
    on = 0;
    finish_seq(1, "R7");
    cset = 4'b0100;
    tick(); cset = 0;
    tick(); expect_go(10, 1, "R9");
    begin
      int hc;
      hc = if2 ? 1 : 0;
      done = 1;
      for (int k = 0; k < 200; k++) begin
        tick(); done = 0;
        if (if2) hc++; else break;
      end
      chk("R10 hold length", hc, HOLD);
    end
    chk("R9 state kept", state, 1);
    tick(3); chk("R9 self clear", go, 0);
    cset = 4'b1000;
    tick(); cset = 0;
    tick(); expect_go(14, 1, "R9");
    finish_seq(1, "R9");
    lp = 1; cset = 4'b0001;
    tick(); cset = 0;
    tick(); expect_go(4, 5, "R9");
    finish_seq(5, "R9");

    // R13: LP_STANDBY exits only by ON / WKUP1
    wk2 = 1; mon = 1;
    tick(3); chk("R13 ignored", go, 0); chk("R13 state", state, 5);
    wk2 = 0; mon = 0; wk1 = 1;
    tick(); expect_go(11, 1, "R13");
    wk1 = 0;
    finish_seq(1, "R13");

    // R4/R12: second SAFE entry halts
    ord = 1;
    tick(); expect_go(3, 4, "R4");
    ord = 0;
    finish_seq(4, "R4");
    chk("R12 halt", halt, 1); chk("R12 count", rcnt, 2);
    tick(3); chk("R12 no recovery", go, 0);
    on = 1;
    tick(3); chk("R12 ignored", go, 0); chk("R12 state", state, 4);
    on = 0;

    rst_n = 0;
    tick(2);
    chk("R1 halt cleared", halt, 0); chk("R1 cnt cleared", rcnt, 0);
    chk("R1 state cleared", state, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc >= WD_LIMIT);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule